// File: doc/BRIEF.md
# Run-time configurable binary-field multiplier

This block multiplies two elements of a binary extension field GF(2^w) held in polynomial basis. The field size `w` and the reduction polynomial are inputs sampled when an operation starts, so a single instance serves any field from GF(2) up to GF(2^WMAX). The multiplier is sequential. In multiply mode it consumes one bit of the first operand per clock. Each cycle it keeps a running copy of the second operand that is multiplied by x and reduced, and it adds that copy into an accumulator wherever the consumed bit is 1.

A squaring mode is also provided. It spreads the bits of the first operand apart, with a zero between each pair, to form the unreduced square of 2w-1 bits. It then folds that value back into w bits, examining one bit per cycle from the top down. Both modes take the same number of cycles. A result is presented on `prod` together with a one-cycle `done` pulse. The result holds until the next completion.

Top module: `gf_shift_mul`

## Requirements
- R1: In multiply mode (`sq_mode`=0), with 1 <= `width` <= WMAX, the result is the product of `opa` and `opb` modulo the field polynomial.
- R2: The field polynomial is x^width plus the polynomial whose coefficients are the low `width` bits of `fpoly` (bit k is the coefficient of x^k). The x^width term is implicit.
- R3: In squaring mode (`sq_mode`=1), the result is `opa` times `opa` modulo the field polynomial, and `opb` is not used. For example, with width 4 and `fpoly`=4'b0011, the operand 4'b1101 gives 4'b1110.
- R4: A start accepted while idle raises `busy`. `done` rises exactly `width` clock edges after the accepting edge, and `busy` falls at the same edge.
- R5: `done` is high for exactly one cycle per completed operation.
- R6: A start with `width` equal to 0 or above WMAX begins no operation. It produces `done` and `err` together on the next edge for one cycle, with `prod` forced to 0.
- R7: Bits of `opa`, `opb` and `fpoly` at or above position `width` have no effect. Bits of `prod` at or above position `width` are always 0.
- R8: `start` while `busy` is high is ignored, and the running operation completes with its original result and timing.
- R9: During and after reset, `busy`, `done` and `err` are 0 and `prod` is 0.
- R10: `prod` changes only at an edge where `done` rises, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| sq_mode | input | 1 | 1 selects squaring, 0 selects multiply |
| width | input | $clog2(WMAX+1) | Field size w |
| fpoly | input | WMAX | Low coefficients of the field polynomial |
| opa | input | WMAX | First operand (multiplier, or operand to square) |
| opb | input | WMAX | Second operand (multiplicand) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected width, pulsed with done |
| prod | output | WMAX | Result, valid from done until the next done |

## Verification
The bench builds the block with WMAX at its default of 16, which gives a 5-bit width port. All field sizes from 1 to 16 are exercised, and the port can also encode the illegal sizes 0 and 17 through 31, so the rejection path is reachable. Results are compared with a bench model that forms the carry-less product and then divides by the polynomial. Directed cases cover the 8-bit field with the known pair 0x57·0x83=0xC1, the 4-bit squaring example, the widest and narrowest fields, junk in the upper operand bits, and a start issued mid-operation.

// File: rtl/gf_shift_mul_pkg.sv
package gf_shift_mul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gf_state_t;
endpackage

// File: rtl/gf_mul_step.sv
// One multiply iteration: conditionally accumulate the running term,
// then advance the term by one power of x with reduction.
module gf_mul_step #(
  parameter int WMAX = 16
) (
  input  logic [WMAX-1:0] term,
  input  logic [WMAX-1:0] acc,
  input  logic            bit_en,
  input  logic [WMAX-1:0] poly,
  input  logic [WMAX-1:0] mask,
  output logic [WMAX-1:0] term_nxt,
  output logic [WMAX-1:0] acc_nxt
);
  logic [WMAX-1:0] top_sel;
  logic            carry;

  always_comb begin
    top_sel  = mask & ~(mask >> 1);
    carry    = |(term & top_sel);
    term_nxt = ((term << 1) ^ (carry ? poly : '0)) & mask;
    acc_nxt  = bit_en ? (acc ^ term) : acc;
  end
endmodule

// File: rtl/gf_sq_step.sv
// One squaring reduction iteration: if the examined bit is set, cancel it
// with the full field polynomial aligned under it.
module gf_sq_step #(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input  logic [DW-1:0] rem,
  input  logic [DW-1:0] full_poly,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] deg,
  output logic [DW-1:0] rem_nxt
);
  logic [PW-1:0] amt;

  always_comb begin
    amt     = pos - deg;
    rem_nxt = rem[pos] ? (rem ^ (full_poly << amt)) : rem;
  end
endmodule

// File: rtl/gf_shift_mul.sv
module gf_shift_mul
  import gf_shift_mul_pkg::*;
#(
  parameter int WMAX = 16,
  localparam int WW  = $clog2(WMAX + 1),
  localparam int DW  = 2 * WMAX,
  localparam int PW  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sq_mode,
  input  logic [WW-1:0]   width,
  input  logic [WMAX-1:0] fpoly,
  input  logic [WMAX-1:0] opa,
  input  logic [WMAX-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [WMAX-1:0] prod
);
  gf_state_t       state_q, state_d;
  logic [WW-1:0]   w_q, w_d;
  logic [WW-1:0]   cnt_q, cnt_d;
  logic            sq_q, sq_d;
  logic [WMAX-1:0] mask_q, mask_d;
  logic [WMAX-1:0] poly_q, poly_d;
  logic [WMAX-1:0] x_q, x_d;
  logic [WMAX-1:0] term_q, term_d;
  logic [WMAX-1:0] acc_q, acc_d;
  logic [DW-1:0]   rem_q, rem_d;
  logic [DW-1:0]   fp_q, fp_d;
  logic [WMAX-1:0] prod_q, prod_d;
  logic            done_q, done_d;
  logic            err_q, err_d;

  logic            width_ok;
  logic [WMAX:0]   mask_wide;
  logic [WMAX-1:0] mask_in;
  logic [WMAX-1:0] xa_in;
  logic [DW-1:0]   spread;
  logic [WMAX-1:0] mul_term, mul_acc;
  logic [DW-1:0]   sq_rem;
  logic [PW-1:0]   sq_pos;
  logic            last_step;

  always_comb begin
    width_ok  = (width != '0) && (width <= WW'(WMAX));
    mask_wide = ((WMAX+1)'(1) << width) - (WMAX+1)'(1);
    mask_in   = mask_wide[WMAX-1:0];
    xa_in     = opa & mask_in;
  end

  // Interleave zeros between operand bits: the unreduced square.
  for (genvar i = 0; i < WMAX; i++) begin : g_spread
    assign spread[2*i]   = xa_in[i];
    assign spread[2*i+1] = 1'b0;
  end

  gf_mul_step #(.WMAX(WMAX)) u_mul (
    .term     (term_q),
    .acc      (acc_q),
    .bit_en   (x_q[0]),
    .poly     (poly_q),
    .mask     (mask_q),
    .term_nxt (mul_term),
    .acc_nxt  (mul_acc)
  );

  assign sq_pos = (PW'(w_q) << 1) - PW'(1) - PW'(cnt_q);

  gf_sq_step #(.DW(DW), .PW(PW)) u_sq (
    .rem       (rem_q),
    .full_poly (fp_q),
    .pos       (sq_pos),
    .deg       (PW'(w_q)),
    .rem_nxt   (sq_rem)
  );

  assign last_step = (cnt_q == (w_q - WW'(1)));

  always_comb begin
    state_d = state_q;
    w_d     = w_q;
    cnt_d   = cnt_q;
    sq_d    = sq_q;
    mask_d  = mask_q;
    poly_d  = poly_q;
    x_d     = x_q;
    term_d  = term_q;
    acc_d   = acc_q;
    rem_d   = rem_q;
    fp_d    = fp_q;
    prod_d  = prod_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (!width_ok) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            prod_d = '0;
          end else begin
            state_d = ST_RUN;
            w_d     = width;
            cnt_d   = '0;
            sq_d    = sq_mode;
            mask_d  = mask_in;
            poly_d  = fpoly & mask_in;
            x_d     = xa_in;
            term_d  = opb & mask_in;
            acc_d   = '0;
            rem_d   = spread;
            fp_d    = DW'(fpoly & mask_in) | (DW'(1) << width);
          end
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + WW'(1);
        if (sq_q) begin
          rem_d = sq_rem;
        end else begin
          term_d = mul_term;
          acc_d  = mul_acc;
          x_d    = x_q >> 1;
        end
        if (last_step) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          prod_d  = sq_q ? (sq_rem[WMAX-1:0] & mask_q) : mul_acc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      w_q     <= '0;
      cnt_q   <= '0;
      sq_q    <= 1'b0;
      mask_q  <= '0;
      poly_q  <= '0;
      x_q     <= '0;
      term_q  <= '0;
      acc_q   <= '0;
      rem_q   <= '0;
      fp_q    <= '0;
      prod_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      w_q     <= w_d;
      cnt_q   <= cnt_d;
      sq_q    <= sq_d;
      mask_q  <= mask_d;
      poly_q  <= poly_d;
      x_q     <= x_d;
      term_q  <= term_d;
      acc_q   <= acc_d;
      rem_q   <= rem_d;
      fp_q    <= fp_d;
      prod_q  <= prod_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
  assign err  = err_q;
  assign prod = prod_q;
endmodule

// File: rtl/gf_shift_mul_chk.sv
module gf_shift_mul_chk #(
  parameter int WMAX = 16,
  localparam int WW  = $clog2(WMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [WW-1:0]   width,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [WMAX-1:0] prod
);
  logic [WW-1:0] wc_q;
  logic [WW:0]   cyc_q;
  logic          bad_w;
  logic [WMAX:0] mwide;

  assign bad_w = (width == '0) || (width > WW'(WMAX));
  assign mwide = ((WMAX+1)'(1) << wc_q) - (WMAX+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q  <= '0;
      cyc_q <= '0;
    end else if (start && !busy && !bad_w) begin
      wc_q  <= width;
      cyc_q <= '0;
    end else if (busy) begin
      cyc_q <= cyc_q + (WW+1)'(1);
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cyc_q == {1'b0, wc_q}));

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc_q < {1'b0, wc_q}));

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !bad_w) |=> busy);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(done && !err));

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_w) |=> (done && err && !busy));

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && (prod == '0)));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((prod & ~mwide[WMAX-1:0]) == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(prod));
endmodule

bind gf_shift_mul gf_shift_mul_chk #(.WMAX(WMAX)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .width (width),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .prod  (prod)
);

// File: tb/tb_gf_shift_mul.sv
module tb_gf_shift_mul;
  localparam int WMAX = 16;
  localparam int WW   = $clog2(WMAX + 1);

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            sq_mode;
  logic [WW-1:0]   width;
  logic [WMAX-1:0] fpoly, opa, opb;
  logic            busy, done, err;
  logic [WMAX-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  gf_shift_mul #(.WMAX(WMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sq_mode(sq_mode),
    .width(width), .fpoly(fpoly), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .err(err), .prod(prod)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: carry-less product, then long division by the polynomial.
  function automatic logic [WMAX-1:0] ref_mul(input logic [WMAX-1:0] a,
      input logic [WMAX-1:0] b, input int w, input logic [WMAX-1:0] p);
    logic [63:0] cl, full, am, bm;
    logic [WMAX-1:0] res;
    am = 64'(a) & ((64'd1 << w) - 1);
    bm = 64'(b) & ((64'd1 << w) - 1);
    full = (64'(p) & ((64'd1 << w) - 1)) | (64'd1 << w);
    cl = '0;
    for (int i = 0; i < w; i++) if (am[i]) cl ^= bm << i;
    for (int k = 2*w - 2; k >= w; k--) if (cl[k]) cl ^= full << (k - w);
    res = cl[WMAX-1:0];
    return res;
  endfunction

  task automatic run_op(input logic [WMAX-1:0] a, input logic [WMAX-1:0] b,
                        input int w, input logic [WMAX-1:0] p, input bit sq,
                        input bit glitch, input string req);
    logic [WMAX-1:0] exp;
    int n;
    exp = sq ? ref_mul(a, a, w, p) : ref_mul(a, b, w, p);
    @(negedge clk);
    start = 1'b1; sq_mode = sq; width = WW'(w); fpoly = p; opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R4 busy after start", {30'd0, busy, done}, 32'h2);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (glitch && n == 1) begin
        start = 1'b1; opa = ~a; opb = ~b; width = WW'(WMAX); sq_mode = ~sq;
      end
      if (glitch && n == 2) start = 1'b0;
      if (!done && n < w) check(busy, "R4 busy held", 32'(busy), 32'd1);
    end
    check(n == w, "R4 latency", 32'(n), 32'(w));
    check(!err, "R6 no err on valid width", 32'(err), 32'd0);
    check(!busy, "R4 busy falls with done", 32'(busy), 32'd0);
    check(prod == exp, req, 32'(prod), 32'(exp));
    @(negedge clk);
    check(!done, "R5 done one cycle", 32'(done), 32'd0);
    if (glitch) check(!busy, "R8 start while busy ignored", 32'(busy), 32'd0);
  endtask

  task automatic run_bad(input int w);
    @(negedge clk);
    start = 1'b1; width = WW'(w); opa = '1; opb = '1; fpoly = '1; sq_mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(done && err && !busy, "R6 reject flags", {29'd0, done, err, busy}, 32'h6);
    check(prod == '0, "R6 prod zero", 32'(prod), 32'd0);
    @(negedge clk);
    check(!done && !err, "R6 one cycle", {30'd0, done, err}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WMAX-1:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; sq_mode = 1'b0; width = '0;
    fpoly = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && prod == '0, "R9 reset state",
          {13'd0, busy, done, err, prod}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && prod == '0, "R9 after release",
          {13'd0, busy, done, err, prod}, 32'd0);

    // R1/R2: byte field 0x57*0x83 = 0xC1 with x^8+x^4+x^3+x+1
    run_op(16'h57, 16'h83, 8, 16'h1B, 1'b0, 1'b0, "R1 R2 byte field");
    check(prod == 16'hC1, "R1 known byte product", 32'(prod), 32'hC1);
    // R3: 1101 squared in width 4, x^4+x+1 -> 1110
    run_op(16'hD, 16'h0, 4, 16'h3, 1'b1, 1'b0, "R3 square example");
    check(prod == 16'hE, "R3 known square", 32'(prod), 32'hE);
    // narrowest and widest fields
    run_op(16'h1, 16'h1, 1, 16'h1, 1'b0, 1'b0, "R1 width 1");
    run_op(16'h1, 16'h0, 1, 16'h0, 1'b1, 1'b0, "R3 width 1");
    run_op(16'hFFFF, 16'hFFFF, 16, 16'h100B, 1'b0, 1'b0, "R1 width 16");
    run_op(16'h8001, 16'h0, 16, 16'h002D, 1'b1, 1'b0, "R3 width 16");
    // R7: junk above width must not matter, result upper bits zero
    run_op(16'hFF35, 16'hA0C7, 6, 16'hFF03, 1'b0, 1'b0, "R7 upper bits ignored");
    check(prod == ref_mul(16'h35, 16'h07, 6, 16'h03), "R7 masked operands",
          32'(prod), 32'(ref_mul(16'h35, 16'h07, 6, 16'h03)));
    check(prod[15:6] == '0, "R7 upper prod zero", 32'(prod), 32'(prod & 16'h3F));
    // R8: start during busy
    run_op(16'h00B7, 16'h0059, 8, 16'h1D, 1'b0, 1'b1, "R8 result unaffected");
    run_op(16'h0A5C, 16'h0, 12, 16'h053, 1'b1, 1'b1, "R8 square unaffected");
    // R6: illegal widths
    run_bad(0);
    run_bad(17);
    run_bad(31);
    // R10: hold with inputs changing, no start
    run_op(16'h1234, 16'h4321, 13, 16'h001B, 1'b0, 1'b0, "R1 width 13");
    held = prod;
    opa = 16'hFFFF; opb = 16'hAAAA; fpoly = 16'h5555; width = 5'd3;
    repeat (4) @(negedge clk);
    check(prod == held && !done, "R10 prod holds", 32'(prod), 32'(held));

    // constrained random
    for (int t = 0; t < 300; t++) begin
      int w;
      logic [WMAX-1:0] a, b, p;
      bit sq;
      w  = 1 + int'($urandom_range(WMAX - 1));
      a  = WMAX'($urandom);
      b  = WMAX'($urandom);
      p  = WMAX'($urandom) | 16'h1;
      sq = bit'($urandom_range(1));
      run_op(a, b, w, p, sq, bit'($urandom_range(7) == 0) && (w >= 4),
             sq ? "R3 random square" : "R1 random multiply");
      check((prod >> w) == '0, "R7 random upper zero", 32'(prod), 32'(prod & ((1 << w) - 1)));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule